// File: doc/BRIEF.md
# Paired-Issue Fetch Mode Sequencer

This block decides, one fetched word at a time, whether the processor front end runs in serial mode or in paired mode. In serial mode each word is a whole instruction. In paired mode two words make up one issue: a floating-point half comes first and a core half second. A floating-point instruction carries a dual flag. When the flag is set in serial mode, the block schedules entry into paired mode. When a floating-point half in paired mode has the flag clear, the block schedules the return to serial mode. Each change takes effect after a fixed grace period: one word on entry, one full pair on exit.

The block also reports the half position of the next word and the fetch increment in words. It also holds the number of delay-slot words owed by the most recently taken delayed branch. That width is fixed by the mode in effect when the branch word is fetched, so a mode change that is already pending does not stretch or shrink the slot. A control-transfer strobe realigns the half position to the floating-point half. Execution and target calculation lie outside the block.

Top module: `dualIssueSeq`

## Requirements
- R1: After reset the block is in serial mode, the half position is the floating-point half (halfCore=0), fetchInc is 1 and delayWords is 1.
- R2: A word is a floating-point instruction when bits 31:26 equal 6'h2C, and bit 9 of such a word is the dual flag. The no-op forms 0xB0000000 (flag clear) and 0xB0000200 (flag set) both qualify. A word with a different opcode never starts a mode change, even if its bit 9 is set (for example 0x00000200).
- R3: In serial mode, a floating-point word with the dual flag set is followed by exactly one more serial word. Paired mode begins with the word after that, at the floating-point half.
- R4: The word fetched during the entry grace step does not cancel or restart the scheduled entry, whatever its dual flag.
- R5: In paired mode, a floating-point half whose dual flag is clear (including 0xB0000000) marks exit. Serial mode begins after that pair and exactly one further pair.
- R6: The floating-point half of the exit grace pair cannot cancel the scheduled exit, even when its dual flag is set.
- R7: In paired mode the half position alternates floating-point, core, floating-point and so on, advancing once per valid word.
- R8: A valid word fetched with ctrlXfer high leaves the half position at the floating-point half for the next word.
- R9: A valid word fetched with branchTaken high sets delayWords to 2 if the block was in paired mode at that fetch, and to 1 otherwise. The value holds until the next taken branch.
- R10: fetchInc is 2 in paired mode and 1 in serial mode.
- R11: While fetchValid is low, mode, half position and delayWords do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetched word is presented this cycle |
| fetchWord | input | 32 | The fetched instruction word |
| branchTaken | input | 1 | The presented word is a taken delayed branch |
| ctrlXfer | input | 1 | The next word starts at a control-transfer target |
| pairedMode | output | 1 | 1 while in paired mode |
| halfCore | output | 1 | Position of the next word: 0 floating-point half, 1 core half |
| fetchInc | output | 2 | Next-fetch increment in words |
| delayWords | output | 2 | Delay-slot width, in words, of the last taken branch |

## Verification
The assertions assume that ctrlXfer and branchTaken matter only when fetchValid is high. They also assume that no control transfer lands in the middle of a pair while an exit is being counted, because a pair only counts once its core half is fetched. The bench drives every strobe together with a valid word, on the falling edge. It redirects control only on pair boundaries while an exit is pending, so these assumptions hold. It also checks that flag changes arriving during both grace periods are ignored.

// File: rtl/dualIssuePkg.sv
package dualIssuePkg;
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 6;
  localparam int DUAL_POS = 9;
  localparam logic [OPC_W-1:0] FP_OPCODE = 6'h2C;
  localparam int CNT_W   = 2;

  typedef struct packed {
    logic advance;
    logic clearHalf;
    logic latchSlot;
    logic slotWide;
    logic paired;
  } seqStrobes_t;

  function automatic logic isFpWord(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: OPC_W] == FP_OPCODE;
  endfunction

  function automatic logic dualFlag(input logic [WORD_W-1:0] w);
    return w[DUAL_POS];
  endfunction
endpackage

// File: rtl/seqControl.sv
module seqControl
  import dualIssuePkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetchValid,
  input  logic        wordIsFp,
  input  logic        wordDual,
  input  logic        branchTaken,
  input  logic        ctrlXfer,
  input  logic        halfCore,
  output seqStrobes_t strobes
);
  logic modeQ, modeD;
  logic pendEntryQ, pendEntryD;
  logic exitSeenQ, exitSeenD;
  logic exitGraceQ, exitGraceD;

  always_comb begin
    modeD      = modeQ;
    pendEntryD = pendEntryQ;
    exitSeenD  = exitSeenQ;
    exitGraceD = exitGraceQ;
    if (fetchValid) begin
      if (!modeQ) begin
        if (pendEntryQ) begin
          modeD      = 1'b1;
          pendEntryD = 1'b0;
        end else if (wordIsFp && wordDual) begin
          pendEntryD = 1'b1;
        end
      end else if (!halfCore) begin
        if (!exitSeenQ && !exitGraceQ && !wordDual)
          exitSeenD = 1'b1;
      end else begin
        if (exitGraceQ) begin
          modeD      = 1'b0;
          exitGraceD = 1'b0;
        end else if (exitSeenQ) begin
          exitGraceD = 1'b1;
          exitSeenD  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ      <= 1'b0;
      pendEntryQ <= 1'b0;
      exitSeenQ  <= 1'b0;
      exitGraceQ <= 1'b0;
    end else begin
      modeQ      <= modeD;
      pendEntryQ <= pendEntryD;
      exitSeenQ  <= exitSeenD;
      exitGraceQ <= exitGraceD;
    end
  end

  always_comb begin
    strobes.advance   = fetchValid;
    strobes.clearHalf = fetchValid && (ctrlXfer || !modeQ || !modeD);
    strobes.latchSlot = fetchValid && branchTaken;
    strobes.slotWide  = modeQ;
    strobes.paired    = modeQ;
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import dualIssuePkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strobes,
  output logic              halfCore,
  output logic [CNT_W-1:0]  fetchInc,
  output logic [CNT_W-1:0]  delayWords
);
  localparam logic [CNT_W-1:0] ONE_WORD  = CNT_W'(1);
  localparam logic [CNT_W-1:0] PAIR_WORD = CNT_W'(2);

  logic halfQ;
  logic [CNT_W-1:0] slotQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halfQ <= 1'b0;
      slotQ <= ONE_WORD;
    end else begin
      if (strobes.clearHalf)    halfQ <= 1'b0;
      else if (strobes.advance) halfQ <= ~halfQ;
      if (strobes.latchSlot)
        slotQ <= strobes.slotWide ? PAIR_WORD : ONE_WORD;
    end
  end

  assign halfCore   = halfQ;
  assign fetchInc   = strobes.paired ? PAIR_WORD : ONE_WORD;
  assign delayWords = slotQ;
endmodule

// File: rtl/dualIssueSeq.sv
module dualIssueSeq
  import dualIssuePkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              branchTaken,
  input  logic              ctrlXfer,
  output logic              pairedMode,
  output logic              halfCore,
  output logic [CNT_W-1:0]  fetchInc,
  output logic [CNT_W-1:0]  delayWords
);
  seqStrobes_t strobes;
  logic wordIsFp, wordDual;
  logic unusedWordBits;

  assign wordIsFp       = isFpWord(fetchWord);
  assign wordDual       = dualFlag(fetchWord);
  assign unusedWordBits = ^fetchWord;

  seqControl i_ctrl (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid),
    .wordIsFp(wordIsFp), .wordDual(wordDual),
    .branchTaken(branchTaken), .ctrlXfer(ctrlXfer),
    .halfCore(halfCore), .strobes(strobes)
  );

  seqDatapath i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .halfCore(halfCore), .fetchInc(fetchInc), .delayWords(delayWords)
  );

  assign pairedMode = strobes.paired;
endmodule

// File: rtl/dualIssueSeqChecker.sv
module dualIssueSeqChecker (
  input logic       clk,
  input logic       rst_n,
  input logic       fetchValid,
  input logic       branchTaken,
  input logic       ctrlXfer,
  input logic       pairedMode,
  input logic       halfCore,
  input logic [1:0] delayWords
);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetchValid |=> ($stable(pairedMode) && $stable(halfCore) && $stable(delayWords)));

  p_entry_at_fp_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pairedMode) |-> !halfCore);

  p_exit_after_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pairedMode) |-> $past(halfCore));

  p_serial_no_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pairedMode |-> !halfCore);

  p_xfer_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && ctrlXfer) |=> !halfCore);

  p_slot_paired_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && branchTaken && pairedMode) |=> delayWords == 2'd2);

  p_slot_serial_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && branchTaken && !pairedMode) |=> delayWords == 2'd1);
endmodule

bind dualIssueSeq dualIssueSeqChecker i_checker (
  .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .branchTaken(branchTaken),
  .ctrlXfer(ctrlXfer), .pairedMode(pairedMode), .halfCore(halfCore),
  .delayWords(delayWords)
);

// File: tb/test_dualIssueSeq.sv
module test_dualIssueSeq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetchValid = 1'b0;
  logic [31:0] fetchWord = '0;
  logic branchTaken = 1'b0;
  logic ctrlXfer = 1'b0;
  logic pairedMode, halfCore;
  logic [1:0] fetchInc, delayWords;
  int errors = 0;
  int checks = 0;

  localparam logic [31:0] FP_DUAL = 32'hB0000200;
  localparam logic [31:0] FP_PLAIN = 32'hB0000000;
  localparam logic [31:0] CORE = 32'h00000000;
  localparam logic [31:0] CORE_B9 = 32'h00000200;

  always #5 clk = ~clk;

  dualIssueSeq i_dualIssueSeq (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .branchTaken(branchTaken), .ctrlXfer(ctrlXfer), .pairedMode(pairedMode),
    .halfCore(halfCore), .fetchInc(fetchInc), .delayWords(delayWords)
  );

  task automatic check(input string req, input logic expP, input logic expH,
                       input logic [1:0] expD);
    logic [1:0] expI;
    expI = expP ? 2'd2 : 2'd1;
    checks++;
    if (pairedMode !== expP || halfCore !== expH || delayWords !== expD ||
        fetchInc !== expI) begin
      errors++;
      $display("FAIL %s: got paired=%0b half=%0b delay=%0d inc=%0d exp paired=%0b half=%0b delay=%0d inc=%0d",
               req, pairedMode, halfCore, delayWords, fetchInc, expP, expH, expD, expI);
    end
  endtask

  // present one word for one cycle, then sample after the edge
  task automatic step(input logic [31:0] w, input logic br, input logic xf,
                      input logic v = 1'b1);
    @(negedge clk);
    fetchValid = v; fetchWord = w; branchTaken = br; ctrlXfer = xf;
    @(posedge clk); #1;
    fetchValid = 1'b0; branchTaken = 1'b0; ctrlXfer = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic enterPaired();
    step(FP_DUAL, 0, 0);
    step(CORE, 0, 0);
  endtask

  task automatic testReset();
    doReset();
    check("R1 reset", 0, 0, 2'd1);
  endtask

  task automatic testEntry();
    doReset();
    step(CORE_B9, 0, 0); check("R2 non-fp bit9", 0, 0, 2'd1);
    step(CORE, 0, 0);    check("R2 non-fp bit9 no entry", 0, 0, 2'd1);
    step(FP_DUAL, 0, 0); check("R3 grace serial", 0, 0, 2'd1);
    step(CORE, 0, 0);    check("R3 paired begins R10", 1, 0, 2'd1);
    step(FP_DUAL, 0, 0); check("R7 core half next", 1, 1, 2'd1);
    step(CORE, 0, 0);    check("R7 fp half next", 1, 0, 2'd1);
  endtask

  task automatic testEntryNoCancel();
    doReset();
    step(FP_DUAL, 0, 0);
    step(FP_PLAIN, 0, 0); check("R4 plain in grace keeps entry", 1, 0, 2'd1);
  endtask

  task automatic testExit();
    doReset();
    enterPaired();
    step(FP_PLAIN, 0, 0); check("R5 marker fp half", 1, 1, 2'd1);
    step(CORE, 0, 0);     check("R5 marker pair done", 1, 0, 2'd1);
    step(FP_DUAL, 0, 0);  check("R6 dual in grace pair", 1, 1, 2'd1);
    step(CORE, 0, 0);     check("R5 serial after grace R10", 0, 0, 2'd1);
    step(CORE, 0, 0);     check("R5 stays serial", 0, 0, 2'd1);
  endtask

  task automatic testIdleAndXfer();
    doReset();
    enterPaired();
    step(FP_DUAL, 0, 0);
    step(FP_PLAIN, 1, 0, 1'b0); check("R11 idle no change", 1, 1, 2'd1);
    step(CORE, 0, 0);
    step(FP_DUAL, 0, 1); check("R8 xfer realign", 1, 0, 2'd1);
  endtask

  task automatic testBranchPaired();
    doReset();
    enterPaired();
    step(FP_DUAL, 0, 0);
    step(CORE, 1, 1); check("R9 branch in paired", 1, 0, 2'd2);
    step(FP_DUAL, 0, 0);
    step(CORE, 0, 0); check("R9 width held", 1, 0, 2'd2);
  endtask

  task automatic testBranchGrace();
    doReset();
    step(FP_DUAL, 0, 0);
    step(CORE, 1, 0); check("R9 branch in entry grace", 1, 0, 2'd1);
    // exit grace pair: branch fetched while still paired
    step(FP_PLAIN, 0, 0);
    step(CORE, 0, 0);
    step(FP_DUAL, 0, 0);
    step(CORE, 1, 0); check("R9 branch in exit grace", 0, 0, 2'd2);
    step(CORE, 1, 0); check("R9 branch serial", 0, 0, 2'd1);
  endtask

  initial begin
    fork
      begin
        testReset();
        testEntry();
        testEntryNoCancel();
        testExit();
        testIdleAndXfer();
        testBranchPaired();
        testBranchGrace();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule